// File: doc/BRIEF.md
# Reliability Characterization Sequencer

This block drives the one-time characterization of an array of mismatch-based identity cells. A single command pulse starts two reads of the cell column through an external readout controller. The first read runs with a positive gate offset and the second with a negative offset of the same size. Each read result is latched into its own word register.

The block then streams both words over a one-bit valid/ready link. The positive-offset word goes first and the negative-offset word second, each least significant bit first.

A combinational helper derives three per-bit words from the two stored results:
- Code: the most likely value of the bit.
- Mask: set where the bit is trustworthy.
- Fault: marks the physically inconsistent pairing.

A bit that reads 0 under positive offset is a firm 0. A bit that reads 1 under negative offset is a firm 1. Every other bit is unreliable.

States and transitions:
- `ST_IDLE` goes to `ST_ARM_POS` on a command.
- `ST_ARM_POS` (one cycle, start pulse) goes to `ST_WAIT_POS`.
- `ST_WAIT_POS` goes to `ST_ARM_NEG` when the read completes.
- `ST_ARM_NEG` goes to `ST_WAIT_NEG`.
- `ST_WAIT_NEG` goes to `ST_SEND_POS` when the read completes.
- `ST_SEND_POS` goes to `ST_SEND_NEG` on the handshake of its last bit.
- `ST_SEND_NEG` goes back to `ST_IDLE` on the handshake of its last bit.

Top module: `relchar_seq`

## Requirements
- R1: After reset, `bias_mode` is 2'b00, `rd_start` and `ser_valid` are 0, and both stored words are 0.
- R2: A `char_req` pulse in idle makes `rd_start` high for exactly one cycle, one cycle after the request. During that cycle `bias_mode` is 2'b01 (positive).
- R3: `bias_mode` stays 2'b01 until `rd_done`. The `rd_word` present with the first `rd_done` appears on `pos_word` the cycle after. In that same cycle `rd_start` pulses again with `bias_mode` 2'b10 (negative).
- R4: The `rd_word` present with the second `rd_done` appears on `neg_word` the cycle after. In that cycle `bias_mode` returns to 2'b00 and `ser_valid` rises.
- R5: The serial link carries exactly 2*WIDTH bits: `pos_word` LSB first, then `neg_word` LSB first. A bit moves only on a cycle with `ser_valid` and `ser_ready` both high. While `ser_valid` is high and `ser_ready` is low, `ser_data` holds.
- R6: `code_word` equals `neg_word`.
- R7: Bit i of `mask_word` is 1 exactly when `pos_word[i]` is 0 or `neg_word[i]` is 1.
- R8: Bit i of `fault_word` is 1 exactly when `pos_word[i]` is 0 and `neg_word[i]` is 1.
- R9: `char_req` outside idle has no effect. No extra `rd_start` is issued, during the run or after it ends.
- R10: `rd_done` while not waiting for a read leaves both stored words unchanged.
- R11: After the last bit's handshake, `ser_valid` is low and a new `char_req` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_req | input | 1 | Characterize command pulse |
| rd_done | input | 1 | Readout controller: read finished, `rd_word` valid |
| rd_word | input | WIDTH | Readout controller result word |
| ser_ready | input | 1 | Serial sink ready |
| rd_start | output | 1 | One-cycle read request to the readout controller |
| bias_mode | output | 2 | Offset select: 00 none, 01 positive, 10 negative |
| pos_word | output | WIDTH | Stored positive-offset read |
| neg_word | output | WIDTH | Stored negative-offset read |
| ser_valid | output | 1 | Serial bit valid |
| ser_data | output | 1 | Serial bit |
| code_word | output | WIDTH | Derived code bits |
| mask_word | output | WIDTH | Derived reliability mask |
| fault_word | output | WIDTH | Inconsistent-pairing flags |

## Verification
The hardest case to reach from the ports is the hand-over between the two serial words under back-pressure. Here the last positive-offset bit and the reload of the negative word share one edge, while `ser_ready` may drop on either side of it.

The vector walk pairs each word pair with a different ready cadence (always, alternate, one in three). This moves that hand-over against stalls at different offsets. Every stalled cycle is checked for a held bit.

Directed steps also issue commands in the middle of a read wait and in the middle of a transmission. They pulse `rd_done` while the block is idle, then confirm that the stored words and the start count are unchanged.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_POS,
        ST_WAIT_POS,
        ST_ARM_NEG,
        ST_WAIT_NEG,
        ST_SEND_POS,
        ST_SEND_NEG
    } seq_state_t;

    typedef enum logic [1:0] {
        BIAS_NONE = 2'b00,
        BIAS_POS  = 2'b01,
        BIAS_NEG  = 2'b10
    } bias_t;
endpackage

// File: rtl/chseq_fsm.sv
module chseq_fsm
    import chseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_req,
    input  logic       rd_done,
    input  logic       sh_last,
    output logic       rd_start,
    output logic [1:0] bias_mode,
    output logic       cap_pos,
    output logic       cap_neg,
    output logic       sh_load,
    output logic       sh_sel_neg
);
    seq_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (char_req) state_d = ST_ARM_POS;
            ST_ARM_POS:  state_d = ST_WAIT_POS;
            ST_WAIT_POS: if (rd_done)  state_d = ST_ARM_NEG;
            ST_ARM_NEG:  state_d = ST_WAIT_NEG;
            ST_WAIT_NEG: if (rd_done)  state_d = ST_SEND_POS;
            ST_SEND_POS: if (sh_last)  state_d = ST_SEND_NEG;
            ST_SEND_NEG: if (sh_last)  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rd_start   = 1'b0;
        bias_mode  = BIAS_NONE;
        cap_pos    = 1'b0;
        cap_neg    = 1'b0;
        sh_load    = 1'b0;
        sh_sel_neg = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARM_POS: begin
                rd_start  = 1'b1;
                bias_mode = BIAS_POS;
            end
            ST_WAIT_POS: begin
                bias_mode = BIAS_POS;
                cap_pos   = rd_done;
            end
            ST_ARM_NEG: begin
                rd_start  = 1'b1;
                bias_mode = BIAS_NEG;
            end
            ST_WAIT_NEG: begin
                bias_mode = BIAS_NEG;
                cap_neg   = rd_done;
                sh_load   = rd_done;
            end
            ST_SEND_POS: begin
                sh_load    = sh_last;
                sh_sel_neg = 1'b1;
            end
            ST_SEND_NEG: ;
            default: ;
        endcase
    end

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

    assert_bias_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_POS && !rd_done) |=> bias_mode == BIAS_POS);

    assert_ignore_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_SEND_NEG) |=> state_q != ST_ARM_POS);

    assert_back_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_NEG && sh_last) |=> state_q == ST_IDLE);
endmodule

// File: rtl/chseq_store.sv
module chseq_store #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pos,
    input  logic             cap_neg,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] pos_q,
    output logic [WIDTH-1:0] neg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            neg_q <= '0;
        end else begin
            if (cap_pos) pos_q <= rd_word;
            if (cap_neg) neg_q <= rd_word;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_pos || cap_neg) |=> ($stable(pos_q) && $stable(neg_q)));
endmodule

// File: rtl/chseq_shifter.sv
module chseq_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             ready,
    output logic             valid,
    output logic             data,
    output logic             last
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [WIDTH-1:0] sh_q;
    logic [CW-1:0]    cnt_q;
    logic             fire;

    assign valid = (cnt_q != '0);
    assign data  = sh_q[0];
    assign fire  = valid && ready;
    assign last  = fire && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_word;
            cnt_q <= FULL;
        end else if (fire) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - ONE;
        end
    end

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !load) |=> (valid && $stable(data)));
endmodule

// File: rtl/chseq_classify.sv
module chseq_classify #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] pos_i,
    input  logic [WIDTH-1:0] neg_i,
    output logic [WIDTH-1:0] code_o,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] fault_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // firm 0: low under positive offset; firm 1: high under negative offset
        assign code_o[i]  = neg_i[i];
        assign mask_o[i]  = ~pos_i[i] | neg_i[i];
        assign fault_o[i] = ~pos_i[i] & neg_i[i];
    end
endmodule

// File: rtl/relchar_seq.sv
module relchar_seq #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_req,
    input  logic             rd_done,
    input  logic [WIDTH-1:0] rd_word,
    input  logic             ser_ready,
    output logic             rd_start,
    output logic [1:0]       bias_mode,
    output logic [WIDTH-1:0] pos_word,
    output logic [WIDTH-1:0] neg_word,
    output logic             ser_valid,
    output logic             ser_data,
    output logic [WIDTH-1:0] code_word,
    output logic [WIDTH-1:0] mask_word,
    output logic [WIDTH-1:0] fault_word
);
    logic cap_pos, cap_neg, sh_load, sh_sel_neg, sh_last;
    logic [WIDTH-1:0] sh_word;

    chseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_req  (char_req),
        .rd_done   (rd_done),
        .sh_last   (sh_last),
        .rd_start  (rd_start),
        .bias_mode (bias_mode),
        .cap_pos   (cap_pos),
        .cap_neg   (cap_neg),
        .sh_load   (sh_load),
        .sh_sel_neg(sh_sel_neg)
    );

    chseq_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_pos(cap_pos),
        .cap_neg(cap_neg),
        .rd_word(rd_word),
        .pos_q  (pos_word),
        .neg_q  (neg_word)
    );

    assign sh_word = sh_sel_neg ? neg_word : pos_word;

    chseq_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_word(sh_word),
        .ready    (ser_ready),
        .valid    (ser_valid),
        .data     (ser_data),
        .last     (sh_last)
    );

    chseq_classify #(.WIDTH(WIDTH)) u_cls (
        .pos_i  (pos_word),
        .neg_i  (neg_word),
        .code_o (code_word),
        .mask_o (mask_word),
        .fault_o(fault_word)
    );
endmodule

// File: tb/sim_relchar_seq.sv
module sim_relchar_seq;
    localparam int W = 16;
    localparam int NV = 6;
    // {pos, neg, ready cadence}
    localparam logic [2*W+1:0] VEC [NV] = '{
        {16'h0000, 16'hFFFF, 2'd0},
        {16'hFFFF, 16'h0000, 2'd1},
        {16'hA5C3, 16'h3C81, 2'd2},
        {16'h1234, 16'hF00F, 2'd0},
        {16'h8001, 16'h8001, 2'd1},
        {16'h00FF, 16'h0F0F, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_req = 1'b0;
    logic rd_done = 1'b0;
    logic [W-1:0] rd_word = '0;
    logic ser_ready = 1'b0;
    logic rd_start, ser_valid, ser_data;
    logic [1:0] bias_mode;
    logic [W-1:0] pos_word, neg_word, code_word, mask_word, fault_word;

    int errors = 0;
    int checks = 0;
    int starts = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    relchar_seq #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .char_req(char_req), .rd_done(rd_done),
        .rd_word(rd_word), .ser_ready(ser_ready), .rd_start(rd_start),
        .bias_mode(bias_mode), .pos_word(pos_word), .neg_word(neg_word),
        .ser_valid(ser_valid), .ser_data(ser_data), .code_word(code_word),
        .mask_word(mask_word), .fault_word(fault_word)
    );

    always @(negedge clk) if (rd_start) starts++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, act=%0d exp<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!rd_start) @(negedge clk);
    endtask

    task automatic give_word(input logic [W-1:0] w);
        @(negedge clk);
        @(negedge clk);
        rd_done = 1'b1;
        rd_word = w;
        @(negedge clk);
        rd_done = 1'b0;
        rd_word = '0;
    endtask

    // collects the stream; mid_cmd injects a command partway through
    task automatic collect(input logic [1:0] mode, input bit mid_cmd, output logic [2*W-1:0] got,
                           output int nbits, output bit stall_bad);
        int k = 0;
        bit pend = 0;
        logic held = 1'b0;
        got = '0;
        nbits = 0;
        stall_bad = 0;
        while (ser_valid || nbits == 0) begin
            if (pend && ser_data !== held) stall_bad = 1;
            ser_ready = (mode == 2'd0) || ((k % (int'(mode) + 1)) == 0);
            char_req = mid_cmd && (nbits == W + 2);
            if (ser_valid && ser_ready) begin
                if (nbits < 2 * W) got[nbits] = ser_data;
                nbits++;
                pend = 0;
            end else if (ser_valid) begin
                pend = 1;
                held = ser_data;
            end
            k++;
            @(negedge clk);
            char_req = 1'b0;
            if (k > 400) break;
        end
        ser_ready = 1'b0;
    endtask

    initial begin
        logic [2*W-1:0] got;
        int nb;
        bit sb;
        int s0;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bias_mode == 2'b00 && !rd_start && !ser_valid, "R1 idle outputs",
              {bias_mode, rd_start, ser_valid}, 0);
        check(pos_word == '0 && neg_word == '0, "R1 stored words", {pos_word, neg_word}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] p, n;
            logic [1:0] md;
            {p, n, md} = VEC[v];
            s0 = starts;
            char_req = 1'b1;
            @(negedge clk);
            char_req = 1'b0;
            // R2: start pulse one cycle after command, positive bias
            check(rd_start && bias_mode == 2'b01, "R2 start with positive bias", {rd_start, bias_mode}, 3'b101);
            // R9: command during wait is ignored
            if (v == 1) char_req = 1'b1;
            give_word(p);
            char_req = 1'b0;
            check(pos_word == p, "R3 pos_word captured", pos_word, p);
            check(rd_start && bias_mode == 2'b10, "R3 negative read start", {rd_start, bias_mode}, 3'b110);
            give_word(n);
            check(neg_word == n, "R4 neg_word captured", neg_word, n);
            check(bias_mode == 2'b00 && ser_valid, "R4 bias off, stream begins", {bias_mode, ser_valid}, 3'b001);
            collect(md, v == 2, got, nb, sb);
            check(nb == 2 * W && got == {n, p}, "R5 serial order and count", {nb[15:0], got}, {16'(2 * W), n, p});
            check(!sb, "R5 data held during stall", 64'(sb), 0);
            check(code_word == n, "R6 code word", code_word, n);
            check(mask_word == (~p | n), "R7 mask word", mask_word, ~p | n);
            check(fault_word == (~p & n), "R8 fault word", fault_word, ~p & n);
            check(!ser_valid, "R11 valid low after last bit", 64'(ser_valid), 0);
            repeat (5) @(negedge clk);
            check(starts == s0 + 2, "R9 no extra read starts", starts - s0, 2);
        end

        // R10: rd_done while idle leaves words untouched
        rd_done = 1'b1;
        rd_word = 16'hDEAD;
        @(negedge clk);
        rd_done = 1'b0;
        @(negedge clk);
        check(pos_word == 16'h00FF && neg_word == 16'h0F0F, "R10 stray done ignored",
              {pos_word, neg_word}, {16'h00FF, 16'h0F0F});

        // R11: new command accepted after a finished run
        char_req = 1'b1;
        @(negedge clk);
        char_req = 1'b0;
        check(rd_start && bias_mode == 2'b01, "R11 new command accepted", {rd_start, bias_mode}, 3'b101);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check(bias_mode == 2'b00 && pos_word == '0 && !ser_valid, "R1 reset mid-run",
              {bias_mode, pos_word, ser_valid}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule